// File: doc/BRIEF.md
# Exclusive Split-Cache Request Router

The router stands between the processor request queue and three cache arrays: a level-one instruction cache, a level-one data cache and a unified level-two cache. The three arrays are kept strictly exclusive, so a line lives in at most one of them. On each step the router looks at the request at the head of the queue and picks exactly one action for the coherence controller. That action is one of: perform the access, move a line from a level-one cache into the level-two cache, move a line from the level-two cache into one of the level-one caches, evict a level-two victim, or send the request to the back of the queue.

Lines never pass directly between the two level-one caches. A line found in the wrong level-one cache first moves down into the level-two cache, and only then comes back up into the correct level-one cache. A single access can therefore take several steps. The head request is popped only when the router decides to perform the access. Any movement or eviction leaves the request at the head, and it is evaluated again on the next step.

The inputs are the presence and room indications, together with the victim addresses, that the arrays report for the current request. The router registers its decision, so it appears one cycle after the inputs it was based on.

Top module: `rtr_exclusive_router`

## Requirements
- R1: The inputs are assumed to honour exclusion: at most one of `l1i_hit_i`, `l1d_hit_i` and `l2_hit_i` is high. A move from the level-two cache into a level-one cache is chosen only when both level-one caches miss.
- R2: For the wrong level-one cache, the outcomes are:
  - If the request hits in the wrong level-one cache and `l2_room_req_i` is high, the router picks the level-one-to-level-two move (code 2) with the request address.
  - If the request hits in the wrong level-one cache and `l2_room_req_i` is low, the router picks the level-two eviction (code 5) with `l2_vic_req_addr_i`.
  - For a fetch, the wrong level-one cache is the data cache. For loads and stores, it is the instruction cache.
  - This rule takes priority over every rule below.
- R3: A hit in the matching level-one cache produces the perform-access action (code 1) with the request address and `miss_o` low.
- R4: On a miss in both level-one caches, when the matching level-one set has room and the level-two cache holds the line, the router picks the level-two-to-instruction move (code 3) for a fetch, or the level-two-to-data move (code 4) otherwise. The address is the request address.
- R5: On a miss in all three caches, when the matching level-one set has room, the router picks perform-access (code 1) with `miss_o` high.
- R6: When the matching level-one set is full and neither level-one cache hits, the outcomes are:
  - If `l2_room_vic_i` is high, the router picks code 2 with the victim address of the matching level-one cache.
  - If `l2_room_vic_i` is low, the router picks code 5 with `l2_vic_vic_addr_i`.
- R7: Request type codes are 0 for load, 1 for fetch, 2 for store and 3 for atomic. `cls_o` reports 0 for a load, 1 for a fetch and 2 for a store or an atomic.
- R8: `pop_o` is high exactly when the action is perform-access. For every movement or eviction it is low.
- R9: A valid request while `busy_i` is high produces the recycle action (code 6) with the request address and `pop_o` low.
- R10: With no valid request the router outputs the no-op action (code 0) and `pop_o` low. The same is true while reset is held.
- R11: Each decision is registered, so outputs reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | A request is at the queue head |
| req_type_i | input | 2 | Request type: 0 load, 1 fetch, 2 store, 3 atomic |
| req_addr_i | input | AW | Request line address |
| busy_i | input | 1 | Coherence controller cannot accept work |
| l1i_hit_i | input | 1 | Request address present in the instruction cache |
| l1d_hit_i | input | 1 | Request address present in the data cache |
| l2_hit_i | input | 1 | Request address present in the level-two cache |
| l1i_room_i | input | 1 | Instruction-cache set of the request has a free way |
| l1d_room_i | input | 1 | Data-cache set of the request has a free way |
| l2_room_req_i | input | 1 | Level-two set of the request address has a free way |
| l2_room_vic_i | input | 1 | Level-two set of the matching level-one victim has a free way |
| l1i_vic_addr_i | input | AW | Instruction-cache victim for the request set |
| l1d_vic_addr_i | input | AW | Data-cache victim for the request set |
| l2_vic_req_addr_i | input | AW | Level-two victim for the request address |
| l2_vic_vic_addr_i | input | AW | Level-two victim for the matching level-one victim address |
| act_o | output | 3 | Action code |
| addr_o | output | AW | Target address of the action |
| cls_o | output | 2 | Request class |
| miss_o | output | 1 | Perform-access is a miss fetch |
| pop_o | output | 1 | Dequeue the head request |

## Verification
The assertions rely on the arrays reporting exclusive presence: never more than one of the three hit flags is high in the same cycle. One property checks this directly as a condition on the inputs. The stimulus table holds only presence patterns with at most one hit flag set. Room flags are combined freely, because the decision order gives them meaning only where they apply. Busy and idle cases are applied as separate directed steps, so every input combination the bench drives is one that the arrays could legally report.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  typedef enum logic [2:0] {
    ACT_NONE      = 3'd0,
    ACT_SERVICE   = 3'd1,
    ACT_L1_TO_L2  = 3'd2,
    ACT_L2_TO_L1I = 3'd3,
    ACT_L2_TO_L1D = 3'd4,
    ACT_L2_EVICT  = 3'd5,
    ACT_RECYCLE   = 3'd6
  } rtr_act_e;

  typedef enum logic [1:0] {
    CLS_LOAD  = 2'd0,
    CLS_FETCH = 2'd1,
    CLS_STORE = 2'd2
  } rtr_cls_e;

  localparam logic [1:0] TYPE_LOAD   = 2'd0;
  localparam logic [1:0] TYPE_FETCH  = 2'd1;
  localparam logic [1:0] TYPE_STORE  = 2'd2;
  localparam logic [1:0] TYPE_ATOMIC = 2'd3;
endpackage

// File: rtl/rtr_classify.sv
module rtr_classify
  import rtr_pkg::*;
(
  input  logic [1:0] type_i,
  output rtr_cls_e   cls_o
);
  always_comb begin
    unique case (type_i)
      TYPE_LOAD:  cls_o = CLS_LOAD;
      TYPE_FETCH: cls_o = CLS_FETCH;
      default:    cls_o = CLS_STORE;  // store and atomic share a class
    endcase
  end
endmodule

// File: rtl/rtr_side_sel.sv
// Orients the L1 indications: own = cache that should serve the class.
module rtr_side_sel #(
  parameter int AW = 32
) (
  input  logic          is_fetch_i,
  input  logic          l1i_hit_i,
  input  logic          l1d_hit_i,
  input  logic          l1i_room_i,
  input  logic          l1d_room_i,
  input  logic [AW-1:0] l1i_vic_addr_i,
  input  logic [AW-1:0] l1d_vic_addr_i,
  output logic          own_hit_o,
  output logic          other_hit_o,
  output logic          own_room_o,
  output logic [AW-1:0] own_vic_addr_o
);
  localparam int NSIDE = 2;
  logic [NSIDE-1:0]         hit_v, room_v;
  logic [NSIDE-1:0][AW-1:0] vic_v;

  assign hit_v  = {l1d_hit_i, l1i_hit_i};
  assign room_v = {l1d_room_i, l1i_room_i};
  assign vic_v  = {l1d_vic_addr_i, l1i_vic_addr_i};

  logic own_idx;
  assign own_idx = ~is_fetch_i;  // 0 = instruction side, 1 = data side

  assign own_hit_o      = hit_v[own_idx];
  assign other_hit_o    = hit_v[~own_idx];
  assign own_room_o     = room_v[own_idx];
  assign own_vic_addr_o = vic_v[own_idx];
endmodule

// File: rtl/rtr_decide.sv
module rtr_decide
  import rtr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          valid_i,
  input  logic          busy_i,
  input  logic          is_fetch_i,
  input  logic          own_hit_i,
  input  logic          other_hit_i,
  input  logic          own_room_i,
  input  logic          l2_hit_i,
  input  logic          l2_room_req_i,
  input  logic          l2_room_vic_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [AW-1:0] own_vic_addr_i,
  input  logic [AW-1:0] l2_vic_req_addr_i,
  input  logic [AW-1:0] l2_vic_vic_addr_i,
  output rtr_act_e      act_o,
  output logic [AW-1:0] addr_o,
  output logic          miss_o
);
  always_comb begin
    act_o  = ACT_NONE;
    addr_o = '0;
    miss_o = 1'b0;
    if (!valid_i) begin
      act_o = ACT_NONE;
    end else if (busy_i) begin
      act_o  = ACT_RECYCLE;
      addr_o = req_addr_i;
    end else if (other_hit_i) begin
      // line sits in the wrong L1: push it down first
      if (l2_room_req_i) begin
        act_o  = ACT_L1_TO_L2;
        addr_o = req_addr_i;
      end else begin
        act_o  = ACT_L2_EVICT;
        addr_o = l2_vic_req_addr_i;
      end
    end else if (own_hit_i) begin
      act_o  = ACT_SERVICE;
      addr_o = req_addr_i;
    end else if (own_room_i) begin
      addr_o = req_addr_i;
      if (l2_hit_i) begin
        act_o = is_fetch_i ? ACT_L2_TO_L1I : ACT_L2_TO_L1D;
      end else begin
        act_o  = ACT_SERVICE;
        miss_o = 1'b1;
      end
    end else if (l2_room_vic_i) begin
      act_o  = ACT_L1_TO_L2;
      addr_o = own_vic_addr_i;
    end else begin
      act_o  = ACT_L2_EVICT;
      addr_o = l2_vic_vic_addr_i;
    end
  end
endmodule

// File: rtl/rtr_exclusive_router.sv
module rtr_exclusive_router
  import rtr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_type_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic          busy_i,
  input  logic          l1i_hit_i,
  input  logic          l1d_hit_i,
  input  logic          l2_hit_i,
  input  logic          l1i_room_i,
  input  logic          l1d_room_i,
  input  logic          l2_room_req_i,
  input  logic          l2_room_vic_i,
  input  logic [AW-1:0] l1i_vic_addr_i,
  input  logic [AW-1:0] l1d_vic_addr_i,
  input  logic [AW-1:0] l2_vic_req_addr_i,
  input  logic [AW-1:0] l2_vic_vic_addr_i,
  output logic [2:0]    act_o,
  output logic [AW-1:0] addr_o,
  output logic [1:0]    cls_o,
  output logic          miss_o,
  output logic          pop_o
);
  rtr_cls_e      cls_d;
  logic          is_fetch;
  logic          own_hit, other_hit, own_room;
  logic [AW-1:0] own_vic_addr;
  rtr_act_e      act_d;
  logic [AW-1:0] addr_d;
  logic          miss_d;

  rtr_classify u_cls (
    .type_i (req_type_i),
    .cls_o  (cls_d)
  );

  assign is_fetch = (cls_d == CLS_FETCH);

  rtr_side_sel #(.AW(AW)) u_side (
    .is_fetch_i     (is_fetch),
    .l1i_hit_i      (l1i_hit_i),
    .l1d_hit_i      (l1d_hit_i),
    .l1i_room_i     (l1i_room_i),
    .l1d_room_i     (l1d_room_i),
    .l1i_vic_addr_i (l1i_vic_addr_i),
    .l1d_vic_addr_i (l1d_vic_addr_i),
    .own_hit_o      (own_hit),
    .other_hit_o    (other_hit),
    .own_room_o     (own_room),
    .own_vic_addr_o (own_vic_addr)
  );

  rtr_decide #(.AW(AW)) u_dec (
    .valid_i           (req_valid_i),
    .busy_i            (busy_i),
    .is_fetch_i        (is_fetch),
    .own_hit_i         (own_hit),
    .other_hit_i       (other_hit),
    .own_room_i        (own_room),
    .l2_hit_i          (l2_hit_i),
    .l2_room_req_i     (l2_room_req_i),
    .l2_room_vic_i     (l2_room_vic_i),
    .req_addr_i        (req_addr_i),
    .own_vic_addr_i    (own_vic_addr),
    .l2_vic_req_addr_i (l2_vic_req_addr_i),
    .l2_vic_vic_addr_i (l2_vic_vic_addr_i),
    .act_o             (act_d),
    .addr_o            (addr_d),
    .miss_o            (miss_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o  <= ACT_NONE;
      addr_o <= '0;
      cls_o  <= CLS_LOAD;
      miss_o <= 1'b0;
      pop_o  <= 1'b0;
    end else begin
      act_o  <= act_d;
      addr_o <= addr_d;
      cls_o  <= cls_d;
      miss_o <= miss_d;
      pop_o  <= (act_d == ACT_SERVICE);
    end
  end
endmodule

// File: rtl/rtr_exclusive_router_chk.sv
module rtr_exclusive_router_chk #(
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [1:0]    req_type_i,
  input logic [AW-1:0] req_addr_i,
  input logic          busy_i,
  input logic          l1i_hit_i,
  input logic          l1d_hit_i,
  input logic          l2_hit_i,
  input logic          l2_room_req_i,
  input logic [AW-1:0] l2_vic_req_addr_i,
  input logic [2:0]    act_o,
  input logic          pop_o
);
  p_exclusive_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({l1i_hit_i, l1d_hit_i, l2_hit_i}));

  p_wrong_l1_evict_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_i && req_type_i == 2'd1 && l1d_hit_i && !l2_room_req_i)
    |=> (act_o == 3'd5));

  p_fetch_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_i && req_type_i == 2'd1 && l1i_hit_i)
    |=> (act_o == 3'd1 && pop_o));

  p_move_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o != 3'd1) |-> !pop_o);

  p_busy_recycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && busy_i) |=> (act_o == 3'd6 && !pop_o));

  p_idle_none_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (act_o == 3'd0));
endmodule

bind rtr_exclusive_router rtr_exclusive_router_chk #(.AW(AW)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .req_valid_i       (req_valid_i),
  .req_type_i        (req_type_i),
  .req_addr_i        (req_addr_i),
  .busy_i            (busy_i),
  .l1i_hit_i         (l1i_hit_i),
  .l1d_hit_i         (l1d_hit_i),
  .l2_hit_i          (l2_hit_i),
  .l2_room_req_i     (l2_room_req_i),
  .l2_vic_req_addr_i (l2_vic_req_addr_i),
  .act_o             (act_o),
  .pop_o             (pop_o)
);

// File: tb/rtr_exclusive_router_test.sv
module rtr_exclusive_router_test;
  localparam int AW = 32;
  localparam logic [AW-1:0] A_REQ = 32'h100, A_VI = 32'h200, A_VD = 32'h300,
                            A_L2R = 32'h400, A_L2V = 32'h500;
  // {type[15:14], l1i_hit,l1d_hit,l2_hit,l1i_room,l1d_room,l2_room_req,l2_room_vic [13:7],
  //  exp_act[6:4], addr_sel[3:2] (0 req,1 own L1 victim,2 L2 victim req,3 L2 victim vic),
  //  exp_miss[1], exp_pop[0]}
  localparam int NV = 17;
  localparam logic [15:0] TBL [NV] = '{
    {2'd1, 7'b1000000, 3'd1, 2'd0, 1'b0, 1'b1},  // R3 fetch hit
    {2'd0, 7'b0100000, 3'd1, 2'd0, 1'b0, 1'b1},  // R3 load hit
    {2'd2, 7'b0100000, 3'd1, 2'd0, 1'b0, 1'b1},  // R7 store
    {2'd3, 7'b0100000, 3'd1, 2'd0, 1'b0, 1'b1},  // R7 atomic
    {2'd1, 7'b0100010, 3'd2, 2'd0, 1'b0, 1'b0},  // R2 fetch in D, room
    {2'd1, 7'b0100000, 3'd5, 2'd2, 1'b0, 1'b0},  // R2 fetch in D, full
    {2'd0, 7'b1000010, 3'd2, 2'd0, 1'b0, 1'b0},  // R2 load in I
    {2'd2, 7'b1000000, 3'd5, 2'd2, 1'b0, 1'b0},  // R2 store in I, full
    {2'd1, 7'b0101010, 3'd2, 2'd0, 1'b0, 1'b0},  // R2 priority over room
    {2'd1, 7'b0011000, 3'd3, 2'd0, 1'b0, 1'b0},  // R4 L2 to I
    {2'd0, 7'b0010100, 3'd4, 2'd0, 1'b0, 1'b0},  // R4 L2 to D
    {2'd1, 7'b0001000, 3'd1, 2'd0, 1'b1, 1'b1},  // R5 fetch miss
    {2'd3, 7'b0000100, 3'd1, 2'd0, 1'b1, 1'b1},  // R5 atomic miss
    {2'd1, 7'b0000001, 3'd2, 2'd1, 1'b0, 1'b0},  // R6 I victim down
    {2'd0, 7'b0000001, 3'd2, 2'd1, 1'b0, 1'b0},  // R6 D victim down
    {2'd2, 7'b0010000, 3'd5, 2'd3, 1'b0, 1'b0},  // R6 evict for victim
    {2'd1, 7'b0000010, 3'd5, 2'd3, 1'b0, 1'b0}   // R6 req room irrelevant
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, busy = 1'b0;
  logic [1:0] req_type = '0;
  logic l1i_hit = 0, l1d_hit = 0, l2_hit = 0, l1i_room = 0, l1d_room = 0,
        l2_room_req = 0, l2_room_vic = 0;
  logic [2:0] act;
  logic [AW-1:0] addr;
  logic [1:0] cls;
  logic miss, pop;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtr_exclusive_router #(.AW(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_type_i(req_type),
    .req_addr_i(A_REQ), .busy_i(busy), .l1i_hit_i(l1i_hit), .l1d_hit_i(l1d_hit),
    .l2_hit_i(l2_hit), .l1i_room_i(l1i_room), .l1d_room_i(l1d_room),
    .l2_room_req_i(l2_room_req), .l2_room_vic_i(l2_room_vic),
    .l1i_vic_addr_i(A_VI), .l1d_vic_addr_i(A_VD), .l2_vic_req_addr_i(A_L2R),
    .l2_vic_vic_addr_i(A_L2V), .act_o(act), .addr_o(addr), .cls_o(cls),
    .miss_o(miss), .pop_o(pop));

  task automatic chk(string req, logic [AW-1:0] got, logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R10 reset state
    chk("R10 reset act", {29'd0, act}, 0);
    chk("R10 reset pop", {31'd0, pop}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      logic [AW-1:0] ea;
      logic [1:0] ec;
      v = TBL[i];
      req_valid = 1'b1;
      req_type = v[15:14];
      {l1i_hit, l1d_hit, l2_hit, l1i_room, l1d_room, l2_room_req, l2_room_vic} = v[13:7];
      case (v[3:2])
        2'd0: ea = A_REQ;
        2'd1: ea = (v[15:14] == 2'd1) ? A_VI : A_VD;
        2'd2: ea = A_L2R;
        default: ea = A_L2V;
      endcase
      ec = (v[15:14] == 2'd3) ? 2'd2 : v[15:14];
      step();  // R11 result registered one edge later
      chk($sformatf("R1-table vec%0d act", i), {29'd0, act}, {29'd0, v[6:4]});
      chk($sformatf("R11 vec%0d addr", i), addr, ea);
      chk($sformatf("R5 vec%0d miss", i), {31'd0, miss}, {31'd0, v[1]});
      chk($sformatf("R8 vec%0d pop", i), {31'd0, pop}, {31'd0, v[0]});
      chk($sformatf("R7 vec%0d cls", i), {30'd0, cls}, {30'd0, ec});
    end

    // R1 exclusion: L2 holds line, both L1 miss, full L1 -> not a move up
    req_type = 2'd0;
    {l1i_hit, l1d_hit, l2_hit, l1i_room, l1d_room, l2_room_req, l2_room_vic} = 7'b0010001;
    step();
    chk("R1 no upward move when L1 full", {29'd0, act}, 2);

    // R9 busy
    busy = 1'b1;
    {l1i_hit, l1d_hit, l2_hit, l1i_room, l1d_room, l2_room_req, l2_room_vic} = 7'b0100000;
    step();
    chk("R9 recycle act", {29'd0, act}, 6);
    chk("R9 recycle addr", addr, A_REQ);
    chk("R9 recycle pop", {31'd0, pop}, 0);
    busy = 1'b0;
    step();
    chk("R9 service after busy", {29'd0, act}, 1);

    // R10 idle
    req_valid = 1'b0;
    step();
    chk("R10 idle act", {29'd0, act}, 0);
    chk("R10 idle pop", {31'd0, pop}, 0);

    // R11: input change not visible before the edge
    req_valid = 1'b1;
    {l1i_hit, l1d_hit, l2_hit, l1i_room, l1d_room, l2_room_req, l2_room_vic} = 7'b0100000;
    #1;
    chk("R11 no comb path", {29'd0, act}, 0);
    step();
    chk("R11 registered", {29'd0, act}, 1);

    // R10 reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R10 async reset act", {29'd0, act}, 0);
    chk("R10 async reset pop", {31'd0, pop}, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule